// File: doc/BRIEF.md
# Pipeline Hazard, Forwarding and Stall Controller

This block steers a five-stage integer pipeline in which fetch and decode share one stage (FD), followed by a register-read stage (RR), then execute (EX), memory (MEM) and writeback (WB). It owns the fetch PC and the instruction register. It decodes the word in FD into register indices, a write target, a load flag and branch information, and carries that state down the pipe. From this state it chooses an operand source for the instruction in RR, detects the case where a load is followed directly by a reader of its target, and resolves conditional branches in RR.

The datapath around it supplies the register file read data for the RR instruction and the result buses of EX, MEM and WB. The block returns the forwarded RR operands, the enables of the pipeline registers, a bubble strobe and a redirect strobe with its target toward the instruction cache. An active-low hold from the caches freezes every register the block owns, including the PC and the instruction register.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: While reset is asserted, pc_o equals RESET_PC (default 0), ir_o is 0, and stall_o, bubble_o and redirect_o are 0. Both operand selects read FWD_RF.
- R2: Each RR operand select uses the code FWD_RF=0, FWD_EX=1, FWD_MEM=2 or FWD_WB=3. The select names the stage that holds the youngest writer of that register: distance 1 gives EX, 2 gives MEM, 3 gives WB, and 4 or more gives RF. op_a_o and op_b_o carry the chosen bus. Operand a is the rs field [25:21] and operand b is the rt field [20:16].
- R3: When several older instructions write the same register, the nearest one wins, in the order EX, then MEM, then WB.
- R4: Register 0 is never forwarded and never causes a stall.
- R5: A load in EX whose target is a source of the RR instruction raises stall_o. While hold_ni=1, this holds the PC and the instruction register for exactly one cycle (ir_en_o=0, bubble_o=1) and inserts a bubble into EX. In the next cycle the operand is taken from FWD_MEM.
- R6: No stall is raised when the instruction after a load is the all-zero no-op or does not read the load's target.
- R7: While hold_ni=0, pc_o, ir_o and all pipeline state keep their values and pipe_en_o is 0. When hold returns, the pipeline resumes where it stopped.
- R8: A low hold overrides a pending load-use stall: bubble_o stays 0 and stall_o remains pending until hold returns.
- R9: A taken branch in RR asserts redirect_o. The target is the branch's PC + 4 + (sign-extended 16-bit offset shifted left by 2). The next pc_o is that target. The word in FD (the delay slot) proceeds and the word fetched behind it is replaced by 0. beq (opcode 000100) is taken on equal operands and bne (opcode 000101) on unequal operands.
- R10: When no branch is taken and no stall or hold is active, pc_o advances by 4 on each cycle.
- R11: Decoding works as follows. Opcode 0 with a nonzero word writes rd [15:11] and reads rs and rt. Opcodes 001xxx write rt and read rs. Opcodes 100xxx are loads that write rt and read rs. Opcodes 101xxx read rs and rt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hold_ni | input | 1 | Cache hold, active low; 0 freezes the core |
| instr_i | input | 32 | Instruction word fetched at pc_o |
| rf_a_i | input | DATA_W | Register file data for rf_raddr_a_o |
| rf_b_i | input | DATA_W | Register file data for rf_raddr_b_o |
| ex_result_i | input | DATA_W | Result of the instruction in EX |
| mem_result_i | input | DATA_W | Result of the instruction in MEM (load data for loads) |
| wb_result_i | input | DATA_W | Result of the instruction in WB |
| pc_o | output | 32 | Fetch PC |
| ir_o | output | 32 | Instruction register (FD stage word) |
| ir_en_o | output | 1 | Enable of PC, instruction register and RR register |
| pipe_en_o | output | 1 | Enable of EX, MEM and WB registers |
| stall_o | output | 1 | Load-use dependence detected |
| bubble_o | output | 1 | A no-op enters EX this cycle |
| rf_raddr_a_o | output | 5 | rs index of the RR instruction |
| rf_raddr_b_o | output | 5 | rt index of the RR instruction |
| fwd_a_o | output | 2 | Source select of operand a |
| fwd_b_o | output | 2 | Source select of operand b |
| op_a_o | output | DATA_W | Forwarded operand a |
| op_b_o | output | DATA_W | Forwarded operand b |
| redirect_o | output | 1 | Taken branch strobe toward the instruction cache |
| redirect_pc_o | output | 32 | Branch target |

## Verification
A producer-to-consumer sweep covers every register index at writer distances of one to four instructions. Each result bus is driven with a distinct tag, so the operand value shows which stage was selected. Register 0 shows that it is never forwarded. Back-to-back writers to the same register separate nearest-first priority from any fixed stage order. Loads are followed by readers through rs, through rt, by a writer that does not read the target and by the zero word; this shows that the stall fires only on a true dependence and lasts one cycle. A hold is applied both on its own and on top of a pending stall. beq and bne with equal and unequal operands and positive, unit and negative offsets cover the redirect path.

// File: rtl/hz_pkg.sv
`timescale 1ns/1ps
package hz_pkg;
  localparam int REG_W   = 5;
  localparam int INSTR_W = 32;
  localparam int PC_W    = 32;

  typedef enum logic [1:0] {
    FWD_RF  = 2'd0,
    FWD_EX  = 2'd1,
    FWD_MEM = 2'd2,
    FWD_WB  = 2'd3
  } fwd_sel_e;

  typedef struct packed {
    logic [REG_W-1:0] rs;
    logic [REG_W-1:0] rt;
    logic [REG_W-1:0] dst;
    logic             wen;
    logic             load;
    logic             use_rs;
    logic             use_rt;
    logic             br;
    logic             br_ne;
    logic [15:0]      off;
  } dec_t;

  typedef struct packed {
    logic [REG_W-1:0] dst;
    logic             wen;
  } wr_t;
endpackage

// File: rtl/hz_decode.sv
`timescale 1ns/1ps
module hz_decode
  import hz_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output dec_t               dec_o
);
  logic [5:0] op;
  assign op = instr_i[31:26];

  always_comb begin
    dec_o     = '0;
    dec_o.rs  = instr_i[25:21];
    dec_o.rt  = instr_i[20:16];
    dec_o.off = instr_i[15:0];
    if (op == 6'b000000) begin
      if (instr_i != '0) begin
        dec_o.dst    = instr_i[15:11];
        dec_o.wen    = 1'b1;
        dec_o.use_rs = 1'b1;
        dec_o.use_rt = 1'b1;
      end
    end else if (op[5:3] == 3'b001) begin
      dec_o.dst    = instr_i[20:16];
      dec_o.wen    = 1'b1;
      dec_o.use_rs = 1'b1;
    end else if (op[5:3] == 3'b100) begin
      dec_o.dst    = instr_i[20:16];
      dec_o.wen    = 1'b1;
      dec_o.load   = 1'b1;
      dec_o.use_rs = 1'b1;
    end else if (op[5:3] == 3'b101) begin
      dec_o.use_rs = 1'b1;
      dec_o.use_rt = 1'b1;
    end else if (op[5:1] == 5'b00010) begin
      dec_o.br     = 1'b1;
      dec_o.br_ne  = op[0];
      dec_o.use_rs = 1'b1;
      dec_o.use_rt = 1'b1;
    end
  end
endmodule

// File: rtl/hz_fwd.sv
`timescale 1ns/1ps
module hz_fwd
  import hz_pkg::*;
(
  input  logic [REG_W-1:0] idx_i,
  input  logic             use_i,
  input  wr_t              ex_i,
  input  logic             ex_load_i,
  input  wr_t              mem_i,
  input  wr_t              wb_i,
  output fwd_sel_e         sel_o,
  output logic             load_hit_o
);
  logic live, ex_hit, mem_hit, wb_hit;
  assign live    = use_i && (idx_i != '0);
  assign ex_hit  = live && ex_i.wen  && (ex_i.dst  == idx_i);
  assign mem_hit = live && mem_i.wen && (mem_i.dst == idx_i);
  assign wb_hit  = live && wb_i.wen  && (wb_i.dst  == idx_i);

  // nearest writer first
  always_comb begin
    if (ex_hit)       sel_o = FWD_EX;
    else if (mem_hit) sel_o = FWD_MEM;
    else if (wb_hit)  sel_o = FWD_WB;
    else              sel_o = FWD_RF;
  end

  assign load_hit_o = ex_hit && ex_load_i;
endmodule

// File: rtl/pipe_hazard_ctrl.sv
`timescale 1ns/1ps
module pipe_hazard_ctrl
  import hz_pkg::*;
#(
  parameter int              DATA_W   = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hold_ni,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [DATA_W-1:0]  rf_a_i,
  input  logic [DATA_W-1:0]  rf_b_i,
  input  logic [DATA_W-1:0]  ex_result_i,
  input  logic [DATA_W-1:0]  mem_result_i,
  input  logic [DATA_W-1:0]  wb_result_i,
  output logic [PC_W-1:0]    pc_o,
  output logic [INSTR_W-1:0] ir_o,
  output logic               ir_en_o,
  output logic               pipe_en_o,
  output logic               stall_o,
  output logic               bubble_o,
  output logic [REG_W-1:0]   rf_raddr_a_o,
  output logic [REG_W-1:0]   rf_raddr_b_o,
  output logic [1:0]         fwd_a_o,
  output logic [1:0]         fwd_b_o,
  output logic [DATA_W-1:0]  op_a_o,
  output logic [DATA_W-1:0]  op_b_o,
  output logic               redirect_o,
  output logic [PC_W-1:0]    redirect_pc_o
);
  localparam int NSRC = 2;

  logic [PC_W-1:0]    pc_q, fd_pc_q, rr_pc_q, next_pc;
  logic [INSTR_W-1:0] ir_q;
  dec_t               fd_dec, rr_q;
  wr_t                ex_q, mem_q, wb_q;
  logic               ex_load_q;

  hz_decode u_dec (.instr_i(ir_q), .dec_o(fd_dec));

  logic [REG_W-1:0]  src_idx [NSRC];
  logic              src_use [NSRC];
  logic [DATA_W-1:0] src_rf  [NSRC];
  logic [DATA_W-1:0] src_val [NSRC];
  fwd_sel_e          src_sel [NSRC];
  logic [NSRC-1:0]   load_hit;

  assign src_idx[0] = rr_q.rs;
  assign src_idx[1] = rr_q.rt;
  assign src_use[0] = rr_q.use_rs;
  assign src_use[1] = rr_q.use_rt;
  assign src_rf[0]  = rf_a_i;
  assign src_rf[1]  = rf_b_i;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    hz_fwd u_fwd (
      .idx_i     (src_idx[g]),
      .use_i     (src_use[g]),
      .ex_i      (ex_q),
      .ex_load_i (ex_load_q),
      .mem_i     (mem_q),
      .wb_i      (wb_q),
      .sel_o     (src_sel[g]),
      .load_hit_o(load_hit[g])
    );
    always_comb begin
      unique case (src_sel[g])
        FWD_EX:  src_val[g] = ex_result_i;
        FWD_MEM: src_val[g] = mem_result_i;
        FWD_WB:  src_val[g] = wb_result_i;
        default: src_val[g] = src_rf[g];
      endcase
    end
  end

  logic stall, advance, cond, taken;
  logic [PC_W-1:0] br_target;

  assign stall     = |load_hit;
  assign advance   = hold_ni && !stall;
  assign cond      = rr_q.br_ne ? (src_val[0] != src_val[1]) : (src_val[0] == src_val[1]);
  assign taken     = rr_q.br && cond && advance;
  assign br_target = rr_pc_q + PC_W'(4) + {{(PC_W-18){rr_q.off[15]}}, rr_q.off, 2'b00};
  assign next_pc   = taken ? br_target : pc_q + PC_W'(4);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q      <= RESET_PC;
      fd_pc_q   <= RESET_PC;
      rr_pc_q   <= RESET_PC;
      ir_q      <= '0;
      rr_q      <= '0;
      ex_q      <= '0;
      ex_load_q <= 1'b0;
      mem_q     <= '0;
      wb_q      <= '0;
    end else if (hold_ni) begin
      wb_q  <= mem_q;
      mem_q <= ex_q;
      if (stall) begin
        ex_q      <= '0;
        ex_load_q <= 1'b0;
      end else begin
        ex_q      <= '{dst: rr_q.dst, wen: rr_q.wen};
        ex_load_q <= rr_q.load;
        pc_q      <= next_pc;
        fd_pc_q   <= pc_q;
        rr_pc_q   <= fd_pc_q;
        ir_q      <= taken ? '0 : instr_i;
        rr_q      <= fd_dec;
      end
    end
  end

  assign pc_o          = pc_q;
  assign ir_o          = ir_q;
  assign ir_en_o       = advance;
  assign pipe_en_o     = hold_ni;
  assign stall_o       = stall;
  assign bubble_o      = hold_ni && stall;
  assign rf_raddr_a_o  = rr_q.rs;
  assign rf_raddr_b_o  = rr_q.rt;
  assign fwd_a_o       = src_sel[0];
  assign fwd_b_o       = src_sel[1];
  assign op_a_o        = src_val[0];
  assign op_b_o        = src_val[1];
  assign redirect_o    = taken;
  assign redirect_pc_o = br_target;
endmodule

// File: rtl/pipe_hazard_ctrl_chk.sv
`timescale 1ns/1ps
module pipe_hazard_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        hold_ni,
  input logic [31:0] pc_o,
  input logic [31:0] ir_o,
  input logic        ir_en_o,
  input logic        stall_o,
  input logic        bubble_o,
  input logic [4:0]  rf_raddr_a_o,
  input logic [4:0]  rf_raddr_b_o,
  input logic [1:0]  fwd_a_o,
  input logic [1:0]  fwd_b_o,
  input logic        redirect_o,
  input logic [31:0] redirect_pc_o
);
  a_r7_hold_freezes_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_ni |=> $stable(pc_o) && $stable(ir_o));

  a_r8_hold_blocks_bubble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_ni |-> !bubble_o && !redirect_o && !ir_en_o);

  a_r5_stall_holds_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bubble_o |=> $stable(pc_o) && $stable(ir_o));

  a_r5_stall_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bubble_o |=> !stall_o);

  a_r4_zero_not_fwd_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_raddr_a_o == 5'd0) |-> (fwd_a_o == 2'd0));

  a_r4_zero_not_fwd_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_raddr_b_o == 5'd0) |-> (fwd_b_o == 2'd0));

  a_r9_redirect_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |=> (pc_o == $past(redirect_pc_o)) && (ir_o == 32'd0));

  a_r10_sequential_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_ni && !stall_o && !redirect_o) |=> (pc_o == $past(pc_o) + 32'd4));
endmodule

bind pipe_hazard_ctrl pipe_hazard_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .hold_ni      (hold_ni),
  .pc_o         (pc_o),
  .ir_o         (ir_o),
  .ir_en_o      (ir_en_o),
  .stall_o      (stall_o),
  .bubble_o     (bubble_o),
  .rf_raddr_a_o (rf_raddr_a_o),
  .rf_raddr_b_o (rf_raddr_b_o),
  .fwd_a_o      (fwd_a_o),
  .fwd_b_o      (fwd_b_o),
  .redirect_o   (redirect_o),
  .redirect_pc_o(redirect_pc_o)
);

// File: tb/pipe_hazard_ctrl_bench.sv
`timescale 1ns/1ps
module pipe_hazard_ctrl_bench;
  localparam logic [1:0] S_RF = 2'd0, S_EX = 2'd1, S_MEM = 2'd2, S_WB = 2'd3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_ni = 1'b0, hold_ni = 1'b1;
  logic [31:0] imem [0:63];
  logic [31:0] instr, rfa, rfb, exv, memv, wbv;
  logic [31:0] pc, ir, rpc, opa, opb;
  logic        ir_en, pipe_en, stall, bubble, redir;
  logic [4:0]  ra, rb;
  logic [1:0]  fa, fb;

  assign instr = imem[pc[7:2]];

  pipe_hazard_ctrl u_pipe_hazard_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .hold_ni(hold_ni), .instr_i(instr),
    .rf_a_i(rfa), .rf_b_i(rfb), .ex_result_i(exv), .mem_result_i(memv),
    .wb_result_i(wbv), .pc_o(pc), .ir_o(ir), .ir_en_o(ir_en),
    .pipe_en_o(pipe_en), .stall_o(stall), .bubble_o(bubble),
    .rf_raddr_a_o(ra), .rf_raddr_b_o(rb), .fwd_a_o(fa), .fwd_b_o(fb),
    .op_a_o(opa), .op_b_o(opb), .redirect_o(redir), .redirect_pc_o(rpc)
  );

  int vectors = 0, fails = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  function automatic logic [31:0] e_ori(input logic [4:0] rt, input logic [4:0] rs, input logic [15:0] imm);
    return {6'b001101, rs, rt, imm};
  endfunction
  function automatic logic [31:0] e_or(input logic [4:0] rd, input logic [4:0] rs, input logic [4:0] rt);
    return {6'b000000, rs, rt, rd, 5'd0, 6'b100101};
  endfunction
  function automatic logic [31:0] e_lw(input logic [4:0] rt, input logic [4:0] rs, input logic [15:0] off);
    return {6'b100011, rs, rt, off};
  endfunction
  function automatic logic [31:0] e_br(input logic ne, input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] off);
    return {5'b00010, ne, rs, rt, off};
  endfunction

  function automatic logic [31:0] val_of(input logic [1:0] s, input logic b);
    case (s)
      S_EX:    return exv;
      S_MEM:   return memv;
      S_WB:    return wbv;
      default: return b ? rfb : rfa;
    endcase
  endfunction

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic start();
    hold_ni = 1'b1;
    rst_ni  = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    rst_ni = 1'b1;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) imem[i] = 32'd0;
    rfa = 32'hCA00_0001; rfb = 32'hCB00_0002;
    exv = 32'hEE00_0003; memv = 32'hAA00_0004; wbv = 32'hBB00_0005;
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    clear_mem();
    // R1 reset state
    hold_ni = 1'b1; rst_ni = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 pc", pc, 32'd0);
    chk("R1 ir", ir, 32'd0);
    chk("R1 stall", {31'd0, stall}, 32'd0);
    chk("R1 bubble", {31'd0, bubble}, 32'd0);
    chk("R1 redirect", {31'd0, redir}, 32'd0);
    chk("R1 fwd", {28'd0, fa, fb}, 32'd0);
    rst_ni = 1'b1;

    // R2 / R4 distance sweep over every register
    for (int d = 1; d <= 4; d++) begin
      for (int p = 0; p < 32; p++) begin
        logic [1:0] es;
        clear_mem();
        imem[0] = e_ori(5'(p), 5'd0, 16'h0001);
        imem[d] = e_or(5'd29, 5'(p), 5'(p));
        start();
        step(d + 2);
        es = (p == 0) ? S_RF : (d == 1) ? S_EX : (d == 2) ? S_MEM : (d == 3) ? S_WB : S_RF;
        chk($sformatf("R2 R4 fwd_a d=%0d p=%0d", d, p), {30'd0, fa}, {30'd0, es});
        chk($sformatf("R2 R4 fwd_b d=%0d p=%0d", d, p), {30'd0, fb}, {30'd0, es});
        chk($sformatf("R2 op_a d=%0d p=%0d", d, p), opa, val_of(es, 1'b0));
        chk($sformatf("R2 op_b d=%0d p=%0d", d, p), opb, val_of(es, 1'b1));
        chk($sformatf("R4 stall d=%0d p=%0d", d, p), {31'd0, stall}, 32'd0);
      end
    end

    // R2 R11 R-type writer then ori reader, forwarded value
    clear_mem();
    exv = 32'h0081_0000;
    imem[0] = e_or(5'd8, 5'd1, 5'd2);
    imem[1] = 32'h3508_000F;
    start();
    step(3);
    chk("R11 rtype dst fwd_a", {30'd0, fa}, {30'd0, S_EX});
    chk("R2 ori result", opa | 32'h0000_000F, 32'h0081_000F);
    chk("R11 itype no rt read", {30'd0, fb}, {30'd0, S_RF});

    // R3 nearest writer wins
    clear_mem();
    imem[0] = e_ori(5'd5, 5'd0, 16'h1);
    imem[1] = e_ori(5'd5, 5'd0, 16'h2);
    imem[2] = e_or(5'd7, 5'd5, 5'd5);
    start();
    step(4);
    chk("R3 ex over mem", {30'd0, fa}, {30'd0, S_EX});
    clear_mem();
    imem[0] = e_ori(5'd5, 5'd0, 16'h1);
    imem[1] = e_ori(5'd5, 5'd0, 16'h2);
    imem[3] = e_or(5'd7, 5'd5, 5'd5);
    start();
    step(5);
    chk("R3 mem over wb", {30'd0, fb}, {30'd0, S_MEM});

    // R5 R6 load followed by various consumers
    for (int p = 0; p < 32; p++) begin
      for (int m = 0; m < 4; m++) begin
        logic es;
        clear_mem();
        imem[0] = e_lw(5'(p), 5'd0, 16'h0);
        case (m)
          0: imem[1] = e_or(5'd29, 5'(p), 5'd0);
          1: imem[1] = e_or(5'd29, 5'd0, 5'(p));
          2: imem[1] = e_ori(5'(p), 5'd0, 16'h3);
          default: imem[1] = 32'd0;
        endcase
        es = (p != 0) && (m < 2);
        start();
        step(3);
        chk($sformatf("R5 R6 stall p=%0d m=%0d", p, m), {31'd0, stall}, {31'd0, es});
        chk($sformatf("R5 bubble p=%0d m=%0d", p, m), {31'd0, bubble}, {31'd0, es});
        chk($sformatf("R5 ir_en p=%0d m=%0d", p, m), {31'd0, ir_en}, {31'd0, !es});
        step(1);
        chk($sformatf("R5 R6 pc p=%0d m=%0d", p, m), pc, es ? 32'd12 : 32'd16);
        if (es) begin
          chk($sformatf("R5 one cycle p=%0d m=%0d", p, m), {31'd0, stall}, 32'd0);
          chk($sformatf("R5 mem fwd p=%0d m=%0d", p, m),
              {30'd0, (m == 0) ? fa : fb}, {30'd0, S_MEM});
          step(1);
          chk($sformatf("R5 resume p=%0d m=%0d", p, m), pc, 32'd16);
        end
      end
    end

    // R7 hold freezes everything
    clear_mem();
    imem[0] = e_ori(5'd5, 5'd0, 16'h1);
    imem[1] = e_or(5'd7, 5'd5, 5'd5);
    start();
    step(2);
    hold_ni = 1'b0;
    step(3);
    chk("R7 pc held", pc, 32'd8);
    chk("R7 ir held", ir, imem[1]);
    chk("R7 pipe_en", {31'd0, pipe_en}, 32'd0);
    chk("R7 ir_en", {31'd0, ir_en}, 32'd0);
    hold_ni = 1'b1;
    step(1);
    chk("R7 resume fwd", {30'd0, fa}, {30'd0, S_EX});
    chk("R7 resume pc", pc, 32'd12);

    // R8 hold over pending stall
    clear_mem();
    imem[0] = e_lw(5'd4, 5'd0, 16'h0);
    imem[1] = e_or(5'd29, 5'd4, 5'd0);
    start();
    step(3);
    hold_ni = 1'b0;
    #1;
    chk("R8 bubble gated", {31'd0, bubble}, 32'd0);
    chk("R8 stall pending", {31'd0, stall}, 32'd1);
    step(2);
    chk("R8 pc", pc, 32'd12);
    chk("R8 still pending", {31'd0, stall}, 32'd1);
    hold_ni = 1'b1;
    #1;
    chk("R8 bubble on release", {31'd0, bubble}, 32'd1);
    step(1);
    chk("R8 stall cleared", {31'd0, stall}, 32'd0);
    chk("R8 pc after stall", pc, 32'd12);
    step(1);
    chk("R8 pc advance", pc, 32'd16);

    // R9 R10 branches
    for (int ne = 0; ne < 2; ne++) begin
      for (int eq = 0; eq < 2; eq++) begin
        for (int k = 0; k < 3; k++) begin
          logic [15:0] off;
          logic [31:0] tgt;
          logic        tk;
          off = (k == 0) ? 16'h0005 : (k == 1) ? 16'h0001 : 16'hFFFE;
          tgt = 32'd4 + {{14{off[15]}}, off, 2'b00};
          tk  = (ne == 1) ? (eq == 0) : (eq == 1);
          clear_mem();
          if (eq == 1) rfb = rfa;
          imem[0] = e_br(ne[0], 5'd8, 5'd9, off);
          imem[1] = e_or(5'd3, 5'd11, 5'd12);
          imem[2] = e_ori(5'd4, 5'd0, 16'h2);
          imem[tgt[7:2]] = e_ori(5'd6, 5'd0, 16'h7);
          start();
          step(2);
          chk($sformatf("R9 R10 redirect ne=%0d eq=%0d k=%0d", ne, eq, k), {31'd0, redir}, {31'd0, tk});
          if (tk) chk($sformatf("R9 target k=%0d", k), rpc, tgt);
          step(1);
          chk($sformatf("R9 R10 next pc ne=%0d eq=%0d k=%0d", ne, eq, k), pc, tk ? tgt : 32'd12);
          chk($sformatf("R9 squash ne=%0d eq=%0d k=%0d", ne, eq, k), ir, tk ? 32'd0 : imem[2]);
          chk($sformatf("R9 delay slot ne=%0d eq=%0d k=%0d", ne, eq, k), {27'd0, ra}, 32'd11);
          step(1);
          chk($sformatf("R9 R10 fetch ne=%0d eq=%0d k=%0d", ne, eq, k), ir,
              tk ? imem[tgt[7:2]] : imem[3]);
        end
      end
    end

    summary();
  end
endmodule